// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block observes every cycle on a system bus and raises a break request when a cycle matches a programmed condition. The condition has two parts. The first is an address: a 32-bit break address and a 32-bit per-bit mask. The second is a set of cycle attributes held in a 16-bit condition register. These attributes are the bus master (CPU or DMA engine), the access kind (instruction fetch or data access), the direction (read or write) and the operand size. A cycle matches only when the address agrees on every unmasked bit and every selected attribute holds.

Software programs the block through a simple register write/read port. The bus side is a passive observation port: a valid strobe qualifies the address and the attribute signals. On a match the block emits a registered single-cycle break pulse and sets a sticky match flag, which software clears by writing a one to it. A power-on reset clears all programmed state, so the channel starts disabled. A separate manual reset clears only the pending break state and keeps the programmed condition.

Top module: `bus_break_matcher`

## Requirements
- R1: After power-on reset (rst_n low), the address, mask and condition registers read as zero, and brk_pulse and brk_flag are low. With the condition at zero, the channel is disabled.
- R2: The condition register at offset 0x8 keeps only bits 7..0. Bits 15..8 and all higher read bits always return 0, whatever value was written to them.
- R3: When the master field (condition bits 7..6) is 00, no cycle produces a break, whatever the other fields hold.
- R4: In the master field, 01 matches CPU cycles only (bus_master=0), 10 matches DMA cycles only (bus_master=1), and 11 matches both.
- R5: The kind field (bits 5..4) compares against bus_kind (0 = instruction fetch, 1 = data access). The direction field (bits 3..2) compares against bus_dir (0 = read, 1 = write). In each field, 00 means don't care, 01 selects the 0 value, 10 selects the 1 value and 11 accepts either.
- R6: The size field (bits 1..0) set to 00 accepts any bus_size. Any other code (01 byte, 10 word, 11 longword) matches only an equal bus_size.
- R7: An address bit takes part in the compare when its mask bit is 0. When its mask bit is 1, that address bit always matches. A cycle matches when ((bus_addr XOR break address) AND NOT mask) is zero.
- R8: A cycle with bus_valid high that meets all conditions at a clock edge drives brk_pulse high for the following cycle only. A cycle with bus_valid low never produces a pulse.
- R9: brk_flag is set in the same cycle as brk_pulse and stays set until a write with bit 0 = 1 to offset 0xC. Writing 0 there has no effect. If a set and a clear arrive in the same cycle, the set wins.
- R10: A manual reset (mrst_n low at a clock edge) clears brk_pulse and brk_flag. It leaves the address, mask and condition registers unchanged.
- R11: Register writes (reg_we high) take effect at the next clock edge. Reads are combinational: offset 0x0 returns the break address, 0x4 the mask, 0x8 the condition and 0xC the flag in bit 0. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_addr | input | 32 | Bus cycle address |
| bus_master | input | 1 | 0 = CPU, 1 = DMA |
| bus_kind | input | 1 | 0 = instruction fetch, 1 = data access |
| bus_dir | input | 1 | 0 = read, 1 = write |
| bus_size | input | 2 | 01 byte, 10 word, 11 longword |
| brk_pulse | output | 1 | Single-cycle break request |
| brk_flag | output | 1 | Sticky match flag |

## Verification
The assertions assume that all inputs are synchronous to clk and hold steady around each rising edge. They also assume that bus attributes matter only while bus_valid is high, and that rst_n is low from time zero until the first release. The bench meets these assumptions by changing every input one time unit after a rising edge and holding it through the next edge. It holds rst_n low over the first cycles. Its attribute sweep uses only legal single-bit master, kind and direction values, together with all four size codes.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    localparam int REG_AW = 4;
    localparam int COND_W = 8;

    localparam logic [REG_AW-1:0] OFS_BADDR = 4'h0;
    localparam logic [REG_AW-1:0] OFS_BMASK = 4'h4;
    localparam logic [REG_AW-1:0] OFS_COND  = 4'h8;
    localparam logic [REG_AW-1:0] OFS_FLAG  = 4'hC;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_LO   = 2'b01;
    localparam logic [1:0] SEL_HI   = 2'b10;
    localparam logic [1:0] SEL_BOTH = 2'b11;

    localparam logic [1:0] SZ_ANY = 2'b00;

    // Field order fixes the bit positions seen by software: master in 7..6.
    typedef struct packed {
        logic [1:0] master;
        logic [1:0] kind;
        logic [1:0] dir;
        logic [1:0] size;
    } cond_t;

    typedef struct packed {
        logic       master;
        logic       kind;
        logic       dir;
        logic [1:0] size;
    } cyc_attr_t;

    // Two-bit selector against a one-bit attribute.
    // none_is_any chooses whether code 00 accepts everything or nothing.
    function automatic logic sel_accepts(input logic [1:0] sel,
                                         input logic       val,
                                         input logic       none_is_any);
        logic ok;
        case (sel)
            SEL_NONE: ok = none_is_any;
            SEL_LO:   ok = ~val;
            SEL_HI:   ok = val;
            default:  ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bbm_regs.sv
module bbm_regs
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              flag_q,
    output logic [ADDR_W-1:0] brk_addr,
    output logic [ADDR_W-1:0] brk_mask,
    output cond_t             cond,
    output logic              flag_clr,
    output logic [ADDR_W-1:0] reg_rdata
);

    localparam int PAD_COND = ADDR_W - COND_W;
    localparam int PAD_FLAG = ADDR_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] baddr;
        logic [ADDR_W-1:0] bmask;
        cond_t             cond;
    } regs_t;

    regs_t regs_d, regs_q;

    // Next-state and write decode.
    always_comb begin
        regs_d   = regs_q;
        flag_clr = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                OFS_BADDR: regs_d.baddr = reg_wdata;
                OFS_BMASK: regs_d.bmask = reg_wdata;
                OFS_COND:  regs_d.cond  = cond_t'(reg_wdata[COND_W-1:0]);
                OFS_FLAG:  flag_clr     = reg_wdata[0];
                default:   ;
            endcase
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_BADDR: reg_rdata = regs_q.baddr;
            OFS_BMASK: reg_rdata = regs_q.bmask;
            OFS_COND:  reg_rdata = {{PAD_COND{1'b0}}, regs_q.cond};
            OFS_FLAG:  reg_rdata = {{PAD_FLAG{1'b0}}, flag_q};
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign brk_addr = regs_q.baddr;
    assign brk_mask = regs_q.bmask;
    assign cond     = regs_q.cond;

endmodule

// File: rtl/bbm_addr_cmp.sv
module bbm_addr_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [ADDR_W-1:0] brk_mask,
    output logic              hit
);

    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        // A set mask bit forces agreement on this position.
        assign bit_ok[i] = brk_mask[i] | ~(bus_addr[i] ^ brk_addr[i]);
    end

    assign hit = &bit_ok;

endmodule

// File: rtl/bbm_cond_cmp.sv
module bbm_cond_cmp
    import bbm_pkg::*;
(
    input  cond_t     cond,
    input  cyc_attr_t attr,
    output logic      hit
);

    logic master_ok;
    logic kind_ok;
    logic dir_ok;
    logic size_ok;

    always_comb begin
        master_ok = sel_accepts(cond.master, attr.master, 1'b0);
        kind_ok   = sel_accepts(cond.kind,   attr.kind,   1'b1);
        dir_ok    = sel_accepts(cond.dir,    attr.dir,    1'b1);
        size_ok   = (cond.size == SZ_ANY) || (cond.size == attr.size);
        hit       = master_ok & kind_ok & dir_ok & size_ok;
    end

endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_master,
    input  logic              bus_kind,
    input  logic              bus_dir,
    input  logic [1:0]        bus_size,
    output logic              brk_pulse,
    output logic              brk_flag
);

    typedef struct packed {
        logic pulse;
        logic flag;
    } evt_t;

    evt_t              evt_d, evt_q;
    logic [ADDR_W-1:0] baddr_q;
    logic [ADDR_W-1:0] bmask_q;
    cond_t             cond_q;
    logic              flag_clr;
    logic              addr_hit;
    logic              cond_hit;
    logic              cyc_match;
    cyc_attr_t         attr;

    assign attr = '{master: bus_master, kind: bus_kind, dir: bus_dir, size: bus_size};

    bbm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flag_q    (evt_q.flag),
        .brk_addr  (baddr_q),
        .brk_mask  (bmask_q),
        .cond      (cond_q),
        .flag_clr  (flag_clr),
        .reg_rdata (reg_rdata)
    );

    bbm_addr_cmp #(.ADDR_W(ADDR_W)) u_addr_cmp (
        .bus_addr (bus_addr),
        .brk_addr (baddr_q),
        .brk_mask (bmask_q),
        .hit      (addr_hit)
    );

    bbm_cond_cmp u_cond_cmp (
        .cond (cond_q),
        .attr (attr),
        .hit  (cond_hit)
    );

    always_comb begin
        cyc_match   = bus_valid & addr_hit & cond_hit;
        evt_d.pulse = cyc_match;
        // Set has priority over a software clear in the same cycle.
        evt_d.flag  = cyc_match | (evt_q.flag & ~flag_clr);
        if (!mrst_n) begin
            evt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign brk_pulse = evt_q.pulse;
    assign brk_flag  = evt_q.flag;

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mrst_n,
    input logic              reg_we,
    input logic [3:0]        reg_addr,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic              bus_valid,
    input logic [7:0]        cond_bits,
    input logic              brk_pulse,
    input logic              brk_flag
);

    a_r8_pulse_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(bus_valid));

    a_r3_disabled_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_bits[7:6] == 2'b00) |=> !brk_pulse);

    a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> brk_flag);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && mrst_n && !(reg_we && reg_addr == 4'hC && reg_wdata[0])) |=> brk_flag);

    a_r10_mrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !mrst_n |=> (!brk_pulse && !brk_flag));

    a_r10_cond_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrst_n && !reg_we) |=> $stable(cond_bits));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'h8) |-> (reg_rdata[ADDR_W-1:8] == '0));

endmodule

bind bus_break_matcher bbm_checker #(.ADDR_W(ADDR_W)) u_bbm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrst_n    (mrst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .bus_valid (bus_valid),
    .cond_bits (cond_q),
    .brk_pulse (brk_pulse),
    .brk_flag  (brk_flag)
);

// File: tb/bus_break_matcher_bench.sv
module bus_break_matcher_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mrst_n = 1'b1;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_master = 1'b0;
    logic          bus_kind = 1'b0;
    logic          bus_dir = 1'b0;
    logic [1:0]    bus_size = 2'b01;
    logic          brk_pulse;
    logic          brk_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_break_matcher #(.ADDR_W(AW)) u_bus_break_matcher (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrst_n     (mrst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_master (bus_master),
        .bus_kind   (bus_kind),
        .bus_dir    (bus_dir),
        .bus_size   (bus_size),
        .brk_pulse  (brk_pulse),
        .brk_flag   (brk_flag)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [AW-1:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        step();
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [AW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive(input logic v, input logic [AW-1:0] a, input logic m,
                         input logic k, input logic dr, input logic [1:0] s);
        bus_valid  = v;
        bus_addr   = a;
        bus_master = m;
        bus_kind   = k;
        bus_dir    = dr;
        bus_size   = s;
    endtask

    // Expected match from the field definitions, written arithmetically.
    function automatic logic exp_hit(input int c, input int m, input int k,
                                     input int dr, input int s);
        int fm, fk, fd, fs;
        fm = (c >> 6) & 3;
        fk = (c >> 4) & 3;
        fd = (c >> 2) & 3;
        fs = c & 3;
        return (((fm >> m) & 1) == 1)
            && (fk == 0 || ((fk >> k) & 1) == 1)
            && (fd == 0 || ((fd >> dr) & 1) == 1)
            && (fs == 0 || fs == s);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] rv;
        logic [AW-1:0] base;
        base = 32'hA5A5_0F0F;

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        rd(4'h0, rv); check("R1 addr reset", rv, '0);
        rd(4'h4, rv); check("R1 mask reset", rv, '0);
        rd(4'h8, rv); check("R1 cond reset", rv, '0);
        check("R1 pulse reset", {31'b0, brk_pulse}, 0);
        check("R1 flag reset", {31'b0, brk_flag}, 0);
        drive(1'b1, '0, 1'b0, 1'b0, 1'b0, 2'b01);
        step();
        check("R1 disabled after reset", {31'b0, brk_pulse}, 0);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 2'b01);

        // R11 readback, unused offset
        wr(4'h0, 32'h1234_5678);
        wr(4'h4, 32'h0F0F_00FF);
        rd(4'h0, rv); check("R11 addr readback", rv, 32'h1234_5678);
        rd(4'h4, rv); check("R11 mask readback", rv, 32'h0F0F_00FF);
        rd(4'h2, rv); check("R11 unused offset", rv, '0);

        // R3 R4 R5 R6 sweep: every condition against every attribute combination
        wr(4'h0, 32'h0000_1000);
        wr(4'h4, 32'h0);
        for (int c = 0; c < 256; c++) begin
            bus_valid = 1'b0;
            wr(4'h8, 32'hFFFF_AB00 | c);
            rd(4'h8, rv);
            check("R2 cond reserved", rv, c);
            for (int v = 0; v < 32; v++) begin
                drive(1'b1, 32'h0000_1000, v[4], v[3], v[2], v[1:0]);
                step();
                check($sformatf("R3 R4 R5 R6 c=%0h v=%0d", c, v), {31'b0, brk_pulse},
                      {31'b0, exp_hit(c, (v >> 4) & 1, (v >> 3) & 1, (v >> 2) & 1, v & 3)});
            end
        end
        bus_valid = 1'b0;

        // R7 address mask
        wr(4'h0, base);
        wr(4'h8, 32'h0000_00C0);
        for (int i = 0; i < 32; i++) begin
            wr(4'h4, 32'h0);
            drive(1'b1, base ^ (32'h1 << i), 1'b0, 1'b1, 1'b0, 2'b11);
            step();
            check($sformatf("R7 unmasked bit %0d", i), {31'b0, brk_pulse}, 0);
            bus_valid = 1'b0;
            wr(4'h4, 32'h1 << i);
            drive(1'b1, base ^ (32'h1 << i), 1'b1, 1'b0, 1'b1, 2'b10);
            step();
            check($sformatf("R7 masked bit %0d", i), {31'b0, brk_pulse}, 1);
            bus_valid = 1'b0;
            wr(4'h4, 32'h1 << ((i + 1) % 32));
            drive(1'b1, base ^ (32'h1 << i), 1'b1, 1'b0, 1'b1, 2'b10);
            step();
            check($sformatf("R7 other bit masked %0d", i), {31'b0, brk_pulse}, 0);
            bus_valid = 1'b0;
        end
        wr(4'h4, 32'hFFFF_FFFF);
        drive(1'b1, ~base, 1'b0, 1'b0, 1'b0, 2'b01);
        step();
        check("R7 full mask", {31'b0, brk_pulse}, 1);
        bus_valid = 1'b0;
        wr(4'h4, 32'h0);

        // R8 valid qualification and single-cycle pulse
        drive(1'b0, base, 1'b0, 1'b0, 1'b0, 2'b01);
        step();
        check("R8 invalid cycle", {31'b0, brk_pulse}, 0);
        drive(1'b1, base, 1'b0, 1'b0, 1'b0, 2'b01);
        step();
        check("R8 pulse high", {31'b0, brk_pulse}, 1);
        bus_valid = 1'b0;
        step();
        check("R8 pulse one cycle", {31'b0, brk_pulse}, 0);

        // R9 sticky flag
        wr(4'hC, 32'h1);
        check("R9 clear", {31'b0, brk_flag}, 0);
        drive(1'b1, base, 1'b1, 1'b1, 1'b1, 2'b11);
        step();
        check("R9 flag with pulse", {31'b0, brk_flag}, 1);
        bus_valid = 1'b0;
        step(); step();
        check("R9 flag holds", {31'b0, brk_flag}, 1);
        rd(4'hC, rv); check("R11 flag readback", rv, 1);
        wr(4'hC, 32'hFFFF_FFFE);
        check("R9 write zero no effect", {31'b0, brk_flag}, 1);
        wr(4'hC, 32'h1);
        check("R9 write one clears", {31'b0, brk_flag}, 0);
        bus_valid = 1'b1;
        wr(4'hC, 32'h1);
        check("R9 set wins over clear", {31'b0, brk_flag}, 1);
        bus_valid = 1'b0;

        // R10 manual reset
        drive(1'b1, base, 1'b0, 1'b0, 1'b0, 2'b01);
        mrst_n = 1'b0;
        step();
        check("R10 pulse cleared", {31'b0, brk_pulse}, 0);
        check("R10 flag cleared", {31'b0, brk_flag}, 0);
        mrst_n = 1'b1;
        bus_valid = 1'b0;
        rd(4'h0, rv); check("R10 addr kept", rv, base);
        rd(4'h4, rv); check("R10 mask kept", rv, 32'h0);
        rd(4'h8, rv); check("R10 cond kept", rv, 32'hC0);
        bus_valid = 1'b1;
        step();
        check("R10 still armed", {31'b0, brk_pulse}, 1);
        bus_valid = 1'b0;

        // R1 power-on reset mid-run restores the disabled state
        rst_n = 1'b0;
        #1;
        rd(4'h8, rv); check("R1 cond cleared by power-on", rv, '0);
        rd(4'h0, rv); check("R1 addr cleared by power-on", rv, '0);
        check("R1 flag cleared by power-on", {31'b0, brk_flag}, 0);
        step();
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule